// File: doc/BRIEF.md
# Parallel flash command sequencer

This block models a byte-wide NOR-style flash device. A command state machine sits in front of a storage array, and the array size is a power of two set by a parameter. Software-visible writes are not plain stores. Each write cycle is read as one step of a keyed sequence. Two key cycles open the device. A command byte then arms either a single-byte program or, after a second pair of key cycles, the erase of one sector. Program can only clear bits. Erase sets a whole sector back to 0xFF.

The read port is combinational and returns 1, 2 or 4 consecutive bytes, packed little-endian. Four fixed read locations can be overridden by ASCII digits taken from two small configuration inputs. The sector erase walks through the sector one byte per clock. While it runs, `busy` is high and the write port is deaf. Any malformed write cycle produces a one-cycle `err` pulse and sends the sequencer back to its idle state. Such a cycle leaves the array untouched.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `busy` and `err` are low and the sequencer waits for the first key cycle, so a complete program sequence is accepted straight away.
- R2: Write and read addresses are reduced modulo the array size (upper bits dropped) before any decode, so key, command and identity addresses alias every array size.
- R3: A sequence opens with data 0xAA at address 0x5555, followed by data 0x55 at address 0x2AAA or at address 0xAAAA (both after reduction).
- R4: After the two key cycles, command 0xA0 makes the next write store (old byte AND new byte) at its address, then the sequencer returns to idle.
- R5: Command 0x80 followed by a second 0xAA/0x55 key pair and then data 0x30 erases to 0xFF the sector holding the 0x30 write's address; a sector is 2^SECTOR_AW bytes, aligned by clearing the low SECTOR_AW address bits.
- R6: An erase clears one byte per clock; `busy` is high for exactly 2^SECTOR_AW cycles starting the cycle after the 0x30 write, and writes arriving while busy are ignored without raising `err`.
- R7: A write with a wrong address or data for its step, an unknown command byte, or a final erase byte other than 0x30 sets `err` for the one cycle after it, returns to idle, and changes no stored byte.
- R8: `wr_size` encodes 0 = byte, 1 = 2 bytes, 2 or 3 = 4 bytes; any write with a size other than byte is rejected exactly as in R7.
- R9: `rd_size` uses the same encoding; the read returns that many bytes from consecutive addresses (wrapping at the array end), lowest address in bits 7:0, unused upper bytes zero.
- R10: A read byte at address 0x1A002 or 0x1A0A2 returns 0x30 + `region_code` when `region_code` <= 2, else the stored byte.
- R11: A read byte at address 0x1A004 or 0x1A0A4 returns 0x30 + `bcast_code` when `bcast_code` <= 3, else the stored byte.
- R12: Reads reflect the array in the same cycle, including bytes already cleared by an erase that is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data byte |
| wr_size | input | 2 | Write size code (0 = byte) |
| rd_addr | input | ADDR_W | Read address |
| rd_size | input | 2 | Read size code |
| region_code | input | 4 | Digit for the region identity bytes |
| bcast_code | input | 4 | Digit for the broadcast identity bytes |
| rd_data | output | 32 | Little-endian read data |
| busy | output | 1 | Sector erase in progress |
| err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench drives key sequences through aliased addresses and both second-key addresses. A design that masked too late, or accepted only one alias, would reject those sequences with `err`. It programs the same byte twice to catch a plain overwrite in place of the AND. It times each erase to catch an off-by-one sector length or a wrong sector base. It also writes in the middle of an erase: a design that listened during `busy` would carry a key step over, and the next write would then be accepted instead of flagged. Wide reads across the array end and across the identity bytes catch wrong wrap, wrong byte order and wrong digit limits. Bad steps and wide writes are followed by reads of the target byte, to prove nothing was stored.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_WAIT_KEY1,
    SEQ_WAIT_KEY2,
    SEQ_WAIT_OP,
    SEQ_ERA_KEY1,
    SEQ_ERA_KEY2,
    SEQ_ERA_TARGET,
    SEQ_PROG_DATA
  } seq_state_e;

  localparam logic [31:0] KEY1_ADDR    = 32'h0000_5555;
  localparam logic [31:0] KEY2_ADDR_LO = 32'h0000_2AAA;
  localparam logic [31:0] KEY2_ADDR_HI = 32'h0000_AAAA;
  localparam logic [7:0]  KEY1_BYTE    = 8'hAA;
  localparam logic [7:0]  KEY2_BYTE    = 8'h55;
  localparam logic [7:0]  OP_PROGRAM   = 8'hA0;
  localparam logic [7:0]  OP_ERASE     = 8'h80;
  localparam logic [7:0]  OP_SECTOR    = 8'h30;

  localparam logic [31:0] REGION_LOC_A = 32'h0001_A002;
  localparam logic [31:0] REGION_LOC_B = 32'h0001_A0A2;
  localparam logic [31:0] BCAST_LOC_A  = 32'h0001_A004;
  localparam logic [31:0] BCAST_LOC_B  = 32'h0001_A0A4;
  localparam logic [7:0]  ASCII_ZERO   = 8'h30;
  localparam logic [3:0]  REGION_MAX   = 4'd2;
  localparam logic [3:0]  BCAST_MAX    = 4'd3;

  localparam logic [1:0]  SIZE_BYTE    = 2'd0;
  localparam logic [1:0]  SIZE_HALF    = 2'd1;

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr_m,
  input  logic [7:0]        wr_byte,
  input  logic [1:0]        wr_size,
  output logic              prog_we,
  output logic              erase_go,
  output logic              err
);

  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'((64'd1 << ARRAY_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] K1_A  = ADDR_W'(KEY1_ADDR) & AMASK;
  localparam logic [ADDR_W-1:0] K2_A0 = ADDR_W'(KEY2_ADDR_LO) & AMASK;
  localparam logic [ADDR_W-1:0] K2_A1 = ADDR_W'(KEY2_ADDR_HI) & AMASK;

  seq_state_e state_q, state_n;
  logic       bad;
  logic       key1_ok, key2_ok;
  logic       accept;

  assign accept  = wr_en && !busy;
  assign key1_ok = (wr_addr_m == K1_A) && (wr_byte == KEY1_BYTE);
  assign key2_ok = ((wr_addr_m == K2_A0) || (wr_addr_m == K2_A1)) && (wr_byte == KEY2_BYTE);

  always_comb begin
    state_n  = state_q;
    bad      = 1'b0;
    prog_we  = 1'b0;
    erase_go = 1'b0;
    if (accept) begin
      if (wr_size != SIZE_BYTE) begin
        bad = 1'b1;
      end else begin
        case (state_q)
          SEQ_WAIT_KEY1: begin
            if (key1_ok) state_n = SEQ_WAIT_KEY2;
            else         bad     = 1'b1;
          end
          SEQ_WAIT_KEY2: begin
            if (key2_ok) state_n = SEQ_WAIT_OP;
            else         bad     = 1'b1;
          end
          SEQ_WAIT_OP: begin
            if (wr_byte == OP_PROGRAM)    state_n = SEQ_PROG_DATA;
            else if (wr_byte == OP_ERASE) state_n = SEQ_ERA_KEY1;
            else                          bad     = 1'b1;
          end
          SEQ_ERA_KEY1: begin
            if (key1_ok) state_n = SEQ_ERA_KEY2;
            else         bad     = 1'b1;
          end
          SEQ_ERA_KEY2: begin
            if (key2_ok) state_n = SEQ_ERA_TARGET;
            else         bad     = 1'b1;
          end
          SEQ_ERA_TARGET: begin
            if (wr_byte == OP_SECTOR) begin
              erase_go = 1'b1;
              state_n  = SEQ_WAIT_KEY1;
            end else begin
              bad = 1'b1;
            end
          end
          SEQ_PROG_DATA: begin
            prog_we = 1'b1;
            state_n = SEQ_WAIT_KEY1;
          end
          default: bad = 1'b1;
        endcase
      end
      if (bad) state_n = SEQ_WAIT_KEY1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WAIT_KEY1;
      err     <= 1'b0;
    end else begin
      state_q <= state_n;
      err     <= bad;
    end
  end

endmodule

// File: rtl/flash_sector_eraser.sv
module flash_sector_eraser #(
  parameter int ARRAY_AW  = 12,
  parameter int SECTOR_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ARRAY_AW-1:0] start_addr,
  output logic                busy,
  output logic                we,
  output logic [ARRAY_AW-1:0] waddr
);

  localparam int BASE_W = ARRAY_AW - SECTOR_AW;
  localparam logic [SECTOR_AW-1:0] LAST_OFF = '1;

  logic                 busy_q, busy_n;
  logic [BASE_W-1:0]    base_q, base_n;
  logic [SECTOR_AW-1:0] off_q, off_n;
  logic                 base_en, off_en;

  always_comb begin
    busy_n  = busy_q;
    base_n  = base_q;
    off_n   = off_q;
    base_en = 1'b0;
    off_en  = 1'b0;
    if (busy_q) begin
      off_en = 1'b1;
      off_n  = off_q + 1'b1;
      if (off_q == LAST_OFF) busy_n = 1'b0;
    end else if (start) begin
      busy_n  = 1'b1;
      base_en = 1'b1;
      base_n  = start_addr[ARRAY_AW-1:SECTOR_AW];
      off_en  = 1'b1;
      off_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      off_q  <= '0;
    end else begin
      busy_q <= busy_n;
      if (base_en) base_q <= base_n;
      if (off_en)  off_q  <= off_n;
    end
  end

  assign busy  = busy_q;
  assign we    = busy_q;
  assign waddr = {base_q, off_q};

endmodule

// File: rtl/flash_id_overlay.sv
module flash_id_overlay
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 12
) (
  input  logic [ADDR_W-1:0] lane_addr,
  input  logic [7:0]        stored,
  input  logic [3:0]        region_code,
  input  logic [3:0]        bcast_code,
  output logic [7:0]        lane_byte
);

  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'((64'd1 << ARRAY_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] RG_A  = ADDR_W'(REGION_LOC_A) & AMASK;
  localparam logic [ADDR_W-1:0] RG_B  = ADDR_W'(REGION_LOC_B) & AMASK;
  localparam logic [ADDR_W-1:0] BC_A  = ADDR_W'(BCAST_LOC_A) & AMASK;
  localparam logic [ADDR_W-1:0] BC_B  = ADDR_W'(BCAST_LOC_B) & AMASK;

  logic at_region, at_bcast;

  assign at_region = (lane_addr == RG_A) || (lane_addr == RG_B);
  assign at_bcast  = (lane_addr == BC_A) || (lane_addr == BC_B);

  always_comb begin
    lane_byte = stored;
    if (at_region && (region_code <= REGION_MAX))
      lane_byte = ASCII_ZERO + {4'h0, region_code};
    else if (at_bcast && (bcast_code <= BCAST_MAX))
      lane_byte = ASCII_ZERO + {4'h0, bcast_code};
  end

endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 12
) (
  input  logic                clk,
  input  logic                we,
  input  logic                and_mode,
  input  logic [ARRAY_AW-1:0] waddr,
  input  logic [7:0]          wbyte,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [1:0]          rd_size,
  input  logic [3:0]          region_code,
  input  logic [3:0]          bcast_code,
  output logic [31:0]         rd_data
);

  localparam int DEPTH = 1 << ARRAY_AW;
  localparam int LANES = 4;
  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'((64'd1 << ARRAY_AW) - 64'd1);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      if (and_mode) cells[waddr] <= cells[waddr] & wbyte;
      else          cells[waddr] <= wbyte;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    logic [7:0]        lane_raw;
    logic [7:0]        lane_out;
    logic              lane_on;

    assign lane_addr = (rd_addr + ADDR_W'(g)) & AMASK;
    assign lane_raw  = cells[lane_addr[ARRAY_AW-1:0]];

    if (g == 0) begin : g_first
      assign lane_on = 1'b1;
    end else if (g == 1) begin : g_second
      assign lane_on = (rd_size != SIZE_BYTE);
    end else begin : g_upper
      assign lane_on = rd_size[1];
    end

    flash_id_overlay #(
      .ADDR_W   (ADDR_W),
      .ARRAY_AW (ARRAY_AW)
    ) u_overlay (
      .lane_addr   (lane_addr),
      .stored      (lane_raw),
      .region_code (region_code),
      .bcast_code  (bcast_code),
      .lane_byte   (lane_out)
    );

    assign rd_data[8*g +: 8] = lane_on ? lane_out : 8'h00;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W    = 24,
  parameter int ARRAY_AW  = 12,
  parameter int SECTOR_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        wr_size,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic [3:0]        region_code,
  input  logic [3:0]        bcast_code,
  output logic [31:0]       rd_data,
  output logic              busy,
  output logic              err
);

  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'((64'd1 << ARRAY_AW) - 64'd1);

  logic [1:0]          rst_pipe;
  logic                rst_int_n;
  logic [ADDR_W-1:0]   wr_addr_m;
  logic                prog_we, erase_go;
  logic                era_we;
  logic [ARRAY_AW-1:0] era_addr;
  logic                arr_we;
  logic                arr_and;
  logic [ARRAY_AW-1:0] arr_addr;
  logic [7:0]          arr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign wr_addr_m = wr_addr & AMASK;

  flash_cmd_decoder #(
    .ADDR_W   (ADDR_W),
    .ARRAY_AW (ARRAY_AW)
  ) u_decoder (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .wr_addr_m (wr_addr_m),
    .wr_byte   (wr_data),
    .wr_size   (wr_size),
    .prog_we   (prog_we),
    .erase_go  (erase_go),
    .err       (err)
  );

  flash_sector_eraser #(
    .ARRAY_AW  (ARRAY_AW),
    .SECTOR_AW (SECTOR_AW)
  ) u_eraser (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (erase_go),
    .start_addr (wr_addr_m[ARRAY_AW-1:0]),
    .busy       (busy),
    .we         (era_we),
    .waddr      (era_addr)
  );

  assign arr_we   = prog_we | era_we;
  assign arr_and  = !era_we;
  assign arr_addr = era_we ? era_addr : wr_addr_m[ARRAY_AW-1:0];
  assign arr_byte = era_we ? 8'hFF : wr_data;

  flash_store #(
    .ADDR_W   (ADDR_W),
    .ARRAY_AW (ARRAY_AW)
  ) u_store (
    .clk         (clk),
    .we          (arr_we),
    .and_mode    (arr_and),
    .waddr       (arr_addr),
    .wbyte       (arr_byte),
    .rd_addr     (rd_addr),
    .rd_size     (rd_size),
    .region_code (region_code),
    .bcast_code  (bcast_code),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/flash_cmd_seq_checker.sv
module flash_cmd_seq_checker #(
  parameter int SECTOR_AW = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [1:0] wr_size,
  input logic       busy,
  input logic       err
);

  localparam logic [SECTOR_AW+1:0] SPAN = (SECTOR_AW+2)'(1 << SECTOR_AW);

  logic [SECTOR_AW+1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R7: an error pulse always follows a write cycle
  assert_err_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en));

  // R6: writes during an erase never raise an error
  assert_quiet_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !err);

  // R6: busy lasts exactly one sector of cycles
  assert_busy_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == SPAN));

  // R5: an erase only starts after a byte-sized 0x30 write
  assert_erase_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && (wr_size == 2'd0) && (wr_data == 8'h30)));

  // R8: a wide write while idle is always rejected
  assert_wide_write_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_size != 2'd0) && !busy) |=> err);

endmodule

bind flash_cmd_seq flash_cmd_seq_checker #(.SECTOR_AW(SECTOR_AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .wr_size (wr_size),
  .busy    (busy),
  .err     (err)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

  localparam int ADDR_W = 24;
  localparam int AW     = 12;
  localparam int SAW    = 10;
  localparam int DEPTH  = 1 << AW;
  localparam int NSEC   = 1 << SAW;
  localparam int AM     = DEPTH - 1;
  localparam int K1     = 'h5555 & AM;
  localparam int K2A    = 'h2AAA & AM;
  localparam int K2B    = 'hAAAA & AM;
  localparam int RG0    = 'h1A002 & AM;
  localparam int RG1    = 'h1A0A2 & AM;
  localparam int BC0    = 'h1A004 & AM;
  localparam int BC1    = 'h1A0A4 & AM;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [1:0]        wr_size;
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0]        rd_size;
  logic [3:0]        region_code;
  logic [3:0]        bcast_code;
  logic [31:0]       rd_data;
  logic              busy;
  logic              err;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .ARRAY_AW(AW), .SECTOR_AW(SAW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_size(wr_size), .rd_addr(rd_addr), .rd_size(rd_size),
    .region_code(region_code), .bcast_code(bcast_code),
    .rd_data(rd_data), .busy(busy), .err(err)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    mon_on = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mm [DEPTH];
  bit         kn [DEPTH];
  int         m_st;
  int         m_left;
  int         m_base;
  bit         m_err;

  initial begin
    for (int i = 0; i < DEPTH; i++) kn[i] = 1'b0;
    m_st = 0; m_left = 0; m_base = 0; m_err = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_err = 1'b0;
    end else begin
      bit bad;
      int a;
      bad = 1'b0;
      if (m_left > 0) begin
        mm[m_base + NSEC - m_left] = 8'hFF;
        kn[m_base + NSEC - m_left] = 1'b1;
        m_left--;
      end else if (wr_en) begin
        a = int'(wr_addr) & AM;
        if (wr_size != 2'd0) bad = 1'b1;
        else begin
          case (m_st)
            0, 3: if (a == K1 && wr_data == 8'hAA) m_st++; else bad = 1'b1;
            1, 4: if ((a == K2A || a == K2B) && wr_data == 8'h55) m_st++; else bad = 1'b1;
            2: if (wr_data == 8'hA0) m_st = 6;
               else if (wr_data == 8'h80) m_st = 3;
               else bad = 1'b1;
            5: if (wr_data == 8'h30) begin
                 m_left = NSEC; m_base = a & ~(NSEC - 1); m_st = 0;
               end else bad = 1'b1;
            default: begin mm[a] = mm[a] & wr_data; m_st = 0; end
          endcase
        end
        if (bad) m_st = 0;
      end
      m_err = bad;
    end
  end

  function automatic bit exp_read(input logic [ADDR_W-1:0] a, input logic [1:0] s,
                                  output logic [31:0] v);
    int n;
    bit ok;
    n  = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    ok = 1'b1;
    v  = 32'h0;
    for (int i = 0; i < n; i++) begin
      int la;
      logic [7:0] b;
      la = (int'(a) + i) & AM;
      b  = mm[la];
      if (!kn[la]) ok = 1'b0;
      if ((la == RG0 || la == RG1) && region_code <= 4'd2) begin
        b = 8'h30 + {4'h0, region_code}; ok = 1'b1;
      end else if ((la == BC0 || la == BC1) && bcast_code <= 4'd3) begin
        b = 8'h30 + {4'h0, bcast_code}; ok = 1'b1;
      end
      v = v | (32'(b) << (8 * i));
    end
    return ok;
  endfunction

  // ---------------- per-cycle comparison ----------------
  always @(posedge clk) begin
    #1;
    if (rst_n && mon_on) begin
      logic [31:0] v;
      chk({phase, " busy"}, {31'h0, busy}, {31'h0, (m_left > 0)});
      chk({phase, " err"}, {31'h0, err}, {31'h0, m_err});
      if (exp_read(rd_addr, rd_size, v)) chk({phase, " rd_data"}, rd_data, v);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [7:0] d, input logic [1:0] s = 2'd0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; wr_size = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [1:0] s,
                        input logic [31:0] exp);
    @(negedge clk);
    rd_addr = ADDR_W'(a); rd_size = s;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic program_byte(input int a, input logic [7:0] d, input bit alt = 1'b0);
    wr('h5555, 8'hAA);
    wr(alt ? 'hAAAA : 'h2AAA, 8'h55);
    wr('h5555, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_start(input int a);
    wr('h5555, 8'hAA);
    wr('h2AAA, 8'h55);
    wr('h5555, 8'h80);
    wr('h5555, 8'hAA);
    wr('h2AAA, 8'h55);
    wr(a, 8'h30);
  endtask

  task automatic erase_timed(input int a);
    int cnt;
    erase_start(a);
    cnt = 0;
    while (busy && cnt < 4 * NSEC) begin
      cnt++;
      @(negedge clk);
    end
    chk("R6 busy length", cnt, NSEC);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_size = '0;
    rd_addr = '0; rd_size = '0; region_code = 4'hF; bcast_code = 4'hF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 busy after reset", {31'h0, busy}, 32'h0);
    chk("R1 err after reset", {31'h0, err}, 32'h0);
    mon_on = 1'b1;

    // R5 / R6: erase every sector from inside, timing each
    phase = "R5";
    erase_timed('h0123);
    erase_timed('h0777);
    erase_timed('h0ABC);
    erase_timed('h0FFF);
    rd_chk("R5 erased low", 'h000, 2'd2, 32'hFFFF_FFFF);
    rd_chk("R5 erased top", 'hFFC, 2'd2, 32'hFFFF_FFFF);

    // R4: program is an AND
    phase = "R4";
    program_byte('h123, 8'h5A);
    rd_chk("R4 first program", 'h123, 2'd0, 32'h5A);
    program_byte('h123, 8'hF0);
    rd_chk("R4 second program ANDs", 'h123, 2'd0, 32'h50);

    // R3: alternate second key address
    phase = "R3";
    program_byte('h200, 8'h3C, 1'b1);
    rd_chk("R3 alt key address", 'h200, 2'd0, 32'h3C);

    // R2: aliased addresses
    phase = "R2";
    wr('h7F5555, 8'hAA);
    wr('h12AAA, 8'h55);
    wr('h3B5555, 8'hA0);
    wr('h345300, 8'h81);
    rd_chk("R2 alias write", 'h300, 2'd0, 32'h81);
    rd_chk("R2 alias read", 'hABC300, 2'd0, 32'h81);

    // R7: malformed steps
    phase = "R7";
    wr('h5555, 8'hAB);
    chk("R7 bad key data err", {31'h0, err}, 32'h1);
    @(negedge clk);
    chk("R7 err one cycle", {31'h0, err}, 32'h0);
    wr('h5555, 8'hAA);
    wr('h1234, 8'h55);
    chk("R7 bad key address err", {31'h0, err}, 32'h1);
    wr('h5555, 8'hAA);
    wr('h2AAA, 8'h55);
    wr('h5555, 8'h90);
    chk("R7 unknown command err", {31'h0, err}, 32'h1);
    wr('h123, 8'h00);
    chk("R7 no program after reject", {31'h0, err}, 32'h1);
    rd_chk("R7 array unchanged", 'h123, 2'd0, 32'h50);
    wr('h5555, 8'hAA);
    wr('h2AAA, 8'h55);
    wr('h5555, 8'h80);
    wr('h5555, 8'hAA);
    wr('h2AAA, 8'h55);
    wr('h400, 8'h31);
    chk("R7 bad sector byte err", {31'h0, err}, 32'h1);
    chk("R7 bad sector byte no erase", {31'h0, busy}, 32'h0);

    // R8: wide writes rejected
    phase = "R8";
    wr('h5555, 8'hAA, 2'd1);
    chk("R8 wide key err", {31'h0, err}, 32'h1);
    wr('h5555, 8'hAA);
    wr('h2AAA, 8'h55);
    wr('h5555, 8'hA0);
    wr('h124, 8'h00, 2'd2);
    chk("R8 wide program err", {31'h0, err}, 32'h1);
    rd_chk("R8 byte untouched", 'h124, 2'd0, 32'hFF);

    // R9: read sizes and wrap
    phase = "R9";
    program_byte('h100, 8'h11);
    program_byte('h101, 8'h22);
    program_byte('h102, 8'h33);
    program_byte('h103, 8'h44);
    rd_chk("R9 size byte", 'h100, 2'd0, 32'h0000_0011);
    rd_chk("R9 size half", 'h100, 2'd1, 32'h0000_2211);
    rd_chk("R9 size word", 'h100, 2'd2, 32'h4433_2211);
    rd_chk("R9 size code 3", 'h100, 2'd3, 32'h4433_2211);
    rd_chk("R9 odd start", 'h101, 2'd1, 32'h0000_3322);
    program_byte('hFFF, 8'hA5);
    program_byte('h000, 8'h5B);
    rd_chk("R9 wrap", 'hFFE, 2'd2, 32'hFF5B_A5FF);

    // R10 / R11: identity bytes
    phase = "R10";
    region_code = 4'd1;
    rd_chk("R10 region first loc", 'h1A002, 2'd0, 32'h31);
    rd_chk("R10 region second loc", 'h1A0A2, 2'd0, 32'h31);
    region_code = 4'd3;
    rd_chk("R10 region out of range", 'h1A002, 2'd0, 32'hFF);
    phase = "R11";
    bcast_code = 4'd3;
    rd_chk("R11 bcast second loc", 'h1A0A4, 2'd0, 32'h33);
    bcast_code = 4'd0;
    rd_chk("R11 bcast first loc", 'h1A004, 2'd0, 32'h30);
    bcast_code = 4'd4;
    rd_chk("R11 bcast out of range", 'h1A004, 2'd0, 32'hFF);
    region_code = 4'd2; bcast_code = 4'd0;
    rd_chk("R11 wide read over both", 'h1A002, 2'd2, 32'hFF30_FF32);
    region_code = 4'hF; bcast_code = 4'hF;

    // R6 / R12: live reads and ignored writes during erase
    phase = "R12";
    program_byte('h5AA, 8'h00);
    erase_start('h4F0);
    repeat (10) @(negedge clk);
    rd_chk("R12 byte not yet erased", 'h5AA, 2'd0, 32'h00);
    rd_chk("R12 first bytes already erased", 'h400, 2'd2, 32'hFFFF_FFFF);
    phase = "R6";
    wr('h5555, 8'hAA);
    chk("R6 write while busy no err", {31'h0, err}, 32'h0);
    while (busy) @(negedge clk);
    rd_chk("R12 byte erased after busy", 'h5AA, 2'd0, 32'hFF);
    wr('h2AAA, 8'h55);
    chk("R6 ignored key left idle", {31'h0, err}, 32'h1);
    program_byte('h5AB, 8'h0F);
    rd_chk("R1 sequencer usable after", 'h5AB, 2'd0, 32'h0F);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule